// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block holds the control state of one memory-mapped, bidirectional I/O port of a parameterised width (eight pins by default). A small register bus (address, write strobe, write data, combinational read data) reaches five registers: a pin-level view, an output data latch, a direction mask, a per-pin pull-up enable mask and an analog-select mask. On the pad side the block drives output data, output enables and pull-up enables, and it receives the raw pin levels. The pin levels pass through a two-stage synchronizer before software can read them.

A direction bit of 1 makes its pin an input with the driver off. A direction bit of 0 turns the driver on, and the pin then carries the latch bit. A weak pull-up is applied only when three things hold together: the pin's own enable bit is set, the global pull-up disable input is low, and the pin is an input. Pins flagged as analog read back as zero in the pin-level view. Whether the low pins start as analog or digital after reset is chosen by a configuration strap input.

Top module: `bidir_port`

## Requirements
- R1: After reset the direction register reads all ones, the latch reads 0, the pull-up enable mask reads 0, every `padOe` bit is 0 and every `padPull` bit is 0.
- R2: After reset with `strapDigital` = 0, the analog-select register (address 4) reads with bits 4..0 set and the others clear (0x1F at the default width). With `strapDigital` = 1 it reads 0. The strap is sampled while `rstN` is low.
- R3: `padOe[i]` equals the inverse of direction bit i, and `padOut` equals the latch, one clock after the write that sets them.
- R4: A read of the latch (address 1) returns the last written latch value, whatever the pin levels are. The latch changes only on a write to address 0 or 1.
- R5: A write to the port address (address 0) updates the output latch in the same way as a write to address 1.
- R6: `padPull[i]` is 1 exactly when pull-enable bit i is 1, direction bit i is 1 (input), and `pullGlobalOff` is 0.
- R7: A read of the port address returns the synchronized pin level ANDed with the inverse of the analog-select mask. A pin change set up before clock edge k is still absent after edge k and appears after edge k+1.
- R8: Addresses 5 to 7 read as 0. Writes to those addresses change no register.
- R9: The direction (address 2), pull-enable (address 3) and analog-select (address 4) registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapDigital | input | 1 | Reset strap: 1 starts the low pins as digital |
| pullGlobalOff | input | 1 | 1 turns off every weak pull-up |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| padIn | input | 8 | Raw pin levels |
| padOut | output | 8 | Output data to the pads |
| padOe | output | 8 | Output driver enables |
| padPull | output | 8 | Weak pull-up enables |

## Verification
The direction and latch registers are each swept through all 256 values. On every value the bench checks readback, the pad enables and the pad data, and for the latch it drives pin levels opposite to the written value, so that a read returning the pins instead of the latch is exposed. Pull-ups are swept over all 256 enable masks, crossed with several direction patterns and both settings of the global disable. This separates the per-pin, direction and global gating terms. The pin view is swept over all 256 pin levels, both with the default analog mask and with a cleared one, which shows the masking. A single step then shows the two-edge synchronizer delay. Both strap settings are taken through reset, and writes to unmapped addresses are followed by a full readback of every register.

// File: rtl/bport_pkg.sv
package bport_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_PORT = 3'd0,
    RA_LAT  = 3'd1,
    RA_DIR  = 3'd2,
    RA_PULL = 3'd3,
    RA_ANA  = 3'd4,
    RA_NONE = 3'd7
  } regSelE;

  typedef struct packed {
    logic   wrLat;
    logic   wrDir;
    logic   wrPull;
    logic   wrAna;
    regSelE rdSel;
  } portStrbT;

endpackage

// File: rtl/bport_ctrl.sv
module bport_ctrl
  import bport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output portStrbT          strb
);

  always_comb begin
    strb = '{wrLat: 1'b0, wrDir: 1'b0, wrPull: 1'b0, wrAna: 1'b0, rdSel: RA_NONE};
    case (regAddr)
      3'd0: begin strb.rdSel = RA_PORT; strb.wrLat  = regWe; end
      3'd1: begin strb.rdSel = RA_LAT;  strb.wrLat  = regWe; end
      3'd2: begin strb.rdSel = RA_DIR;  strb.wrDir  = regWe; end
      3'd3: begin strb.rdSel = RA_PULL; strb.wrPull = regWe; end
      3'd4: begin strb.rdSel = RA_ANA;  strb.wrAna  = regWe; end
      default: strb.rdSel = RA_NONE;
    endcase
  end

  // R5, R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrLat, strb.wrDir, strb.wrPull, strb.wrAna}));

  // R8
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> !(strb.wrLat || strb.wrDir || strb.wrPull || strb.wrAna));

endmodule

// File: rtl/bport_datapath.sv
module bport_datapath
  import bport_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int ANA_N   = 5,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapDigital,
  input  logic             pullGlobalOff,
  input  portStrbT         strb,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdata,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padPull
);

  localparam logic [WIDTH-1:0] ANA_DEF = {{(WIDTH-ANA_N){1'b0}}, {ANA_N{1'b1}}};

  logic [WIDTH-1:0] latQ, dirQ, pullQ, anaQ;
  logic [WIDTH-1:0] syncQ [SYNC_N];
  logic [WIDTH-1:0] pinView;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latQ  <= '0;
      dirQ  <= '1;
      pullQ <= '0;
      anaQ  <= strapDigital ? '0 : ANA_DEF;
    end else begin
      if (strb.wrLat)  latQ  <= wdata;
      if (strb.wrDir)  dirQ  <= wdata;
      if (strb.wrPull) pullQ <= wdata;
      if (strb.wrAna)  anaQ  <= wdata;
    end
  end

  // synchronizer chain, length set by SYNC_N
  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinView = syncQ[SYNC_N-1] & ~anaQ;

  always_comb begin
    case (strb.rdSel)
      RA_PORT: rdata = pinView;
      RA_LAT:  rdata = latQ;
      RA_DIR:  rdata = dirQ;
      RA_PULL: rdata = pullQ;
      RA_ANA:  rdata = anaQ;
      default: rdata = '0;
    endcase
  end

  assign padOut  = latQ;
  assign padOe   = ~dirQ;
  assign padPull = pullQ & dirQ & {WIDTH{~pullGlobalOff}};

  // R3
  dir_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> padOe == ~$past(wdata));

  // R3
  lat_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLat |=> padOut == $past(wdata));

  // R4
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrLat |=> $stable(padOut));

  // R6
  pull_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPull & padOe) == '0);

  // R6
  pull_glb_chk: assert property (@(posedge clk) disable iff (!rstN)
    pullGlobalOff |-> padPull == '0);

endmodule

// File: rtl/bidir_port.sv
module bidir_port
  import bport_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ANA_N  = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapDigital,
  input  logic              pullGlobalOff,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [WIDTH-1:0]  regWdata,
  output logic [WIDTH-1:0]  regRdata,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padPull
);

  portStrbT strb;

  bport_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  bport_datapath #(
    .WIDTH  (WIDTH),
    .ANA_N  (ANA_N),
    .SYNC_N (SYNC_N)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strapDigital  (strapDigital),
    .pullGlobalOff (pullGlobalOff),
    .strb          (strb),
    .wdata         (regWdata),
    .padIn         (padIn),
    .rdata         (regRdata),
    .padOut        (padOut),
    .padOe         (padOe),
    .padPull       (padPull)
  );

endmodule

// File: tb/bidir_port_test.sv
module bidir_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapDigital = 1'b0;
  logic       pullGlobalOff = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic [7:0] padIn = 8'd0;
  logic [7:0] padOut, padOe, padPull;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bidir_port uut (
    .clk(clk), .rstN(rstN), .strapDigital(strapDigital), .pullGlobalOff(pullGlobalOff),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .padPull(padPull)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; strapDigital = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  logic [7:0] v;

  initial begin
    // R1, R2: reset state for the strap at 0
    doReset(1'b0);
    rd(3'd2, v); check("R1 dir reset", v, 8'hFF);
    rd(3'd1, v); check("R1 lat reset", v, 8'h00);
    rd(3'd3, v); check("R1 pull reset", v, 8'h00);
    check("R1 oe reset", padOe, 8'h00);
    check("R1 pull pad reset", padPull, 8'h00);
    rd(3'd4, v); check("R2 ana strap0", v, 8'h1F);

    // R2: the strap at 1 starts every pin as digital
    doReset(1'b1);
    rd(3'd4, v); check("R2 ana strap1", v, 8'h00);
    doReset(1'b0);

    // R9, R3: sweep of the direction register
    for (int i = 0; i < 256; i++) begin
      wr(3'd2, 8'(i));
      rd(3'd2, v); check("R9 dir rb", v, 8'(i));
      check("R3 oe", padOe, ~8'(i));
    end

    // R4, R3: sweep of the latch with pins driven opposite
    for (int i = 0; i < 256; i++) begin
      padIn = ~8'(i);
      wr(3'd1, 8'(i));
      @(negedge clk); @(negedge clk);
      rd(3'd1, v); check("R4 lat rb", v, 8'(i));
      check("R3 padOut", padOut, 8'(i));
    end

    // R5: a write to the port address lands in the latch
    wr(3'd0, 8'hA5);
    rd(3'd1, v); check("R5 port wr lat", v, 8'hA5);
    check("R5 port wr pad", padOut, 8'hA5);

    // R6: pull-up gating
    for (int g = 0; g < 2; g++) begin
      pullGlobalOff = g[0];
      for (int d = 0; d < 4; d++) begin
        logic [7:0] dv;
        dv = (d == 0) ? 8'hFF : (d == 1) ? 8'h00 : (d == 2) ? 8'hF0 : 8'h5A;
        wr(3'd2, dv);
        for (int p = 0; p < 256; p++) begin
          wr(3'd3, 8'(p));
          check("R6 pull", padPull, g[0] ? 8'h00 : (8'(p) & dv));
        end
      end
    end
    pullGlobalOff = 1'b0;
    wr(3'd3, 8'h00);

    // R7: pin view with the default analog mask and with a cleared mask
    wr(3'd2, 8'hFF);
    for (int m = 0; m < 2; m++) begin
      logic [7:0] am;
      am = (m == 0) ? 8'h1F : 8'h00;
      wr(3'd4, am);
      rd(3'd4, v); check("R9 ana rb", v, am);
      for (int i = 0; i < 256; i++) begin
        @(negedge clk); padIn = 8'(i);
        @(negedge clk); @(negedge clk);
        rd(3'd0, v); check("R7 port read", v, 8'(i) & ~am);
      end
    end

    // R7: latency of the two-stage synchronizer
    @(negedge clk); padIn = 8'h00;
    repeat (3) @(negedge clk);
    padIn = 8'hC3;
    @(negedge clk);
    rd(3'd0, v); check("R7 after one edge", v, 8'h00);
    @(negedge clk);
    rd(3'd0, v); check("R7 after two edges", v, 8'hC3);

    // R8: unmapped addresses
    wr(3'd1, 8'h3C); wr(3'd2, 8'h96); wr(3'd3, 8'h81); wr(3'd4, 8'h42);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 8'hFF);
      rd(3'(a), v); check("R8 unmapped read", v, 8'h00);
    end
    rd(3'd1, v); check("R8 lat kept", v, 8'h3C);
    rd(3'd2, v); check("R8 dir kept", v, 8'h96);
    rd(3'd3, v); check("R8 pull kept", v, 8'h81);
    rd(3'd4, v); check("R8 ana kept", v, 8'h42);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule